// File: doc/BRIEF.md
# Two-Pass Flash Converter Control Sequencer

This block is the digital timing and control core of a multichannel 8-bit converter that resolves its result in two 4-bit passes. A free-running clock drives it. The block watches an active-low chip-select and an active-low read strobe. When both strobes are low, it captures a channel number. It then counts out a tracking interval, a coarse pass and a fine pass. The analog inputs are stood in for by one 8-bit sample word per channel.

Each pass is a bank of fifteen threshold comparators that produces a thermometer code, followed by an encoder that turns the code into a nibble.

- The coarse pass compares the upper nibble of the sample against the ladder.
- The fine pass compares the residue: the held sample minus the value rebuilt from the coarse nibble.

A host uses the block in one of two ways, which differ only in how long the read strobe is held low:

- **Mode 0 (wait-state read).** The host holds read low until the new result appears.
- **Mode 1 (pipelined read).** A short read returns the previous result while it launches the next conversion.

The block has three outputs towards the host:

- **Result bus.** An 8-bit bus with a separate drive enable, so it can be tri-stated.
- **Completion flag.** An active-low output that falls when a conversion finishes.
- **Ready request.** An open-drain pull-low request for a host wait line.

Top module: `hfa_seq`

## Requirements
- R1: The channel address is captured at the clock edge that first sees chip-select and read both low while the block is idle. Changes on the address after that edge do not alter the conversion.
- R2: Address value k (binary) selects sample word k, found at bits [8k+7:8k] of the sample bus. With CHAN_BITS=3 there are 8 channels, address 0 to 7.
- R3: The sample is taken at the edge that ends the tracking interval, TRACK_CYC cycles after the start edge. A sample change seen by that edge is converted. A change made after it has no effect on the result.
- R4: The completion flag int_n falls exactly TRACK_CYC+FINE_CYC cycles after the start edge.
- R5 (mode 0, read held low):
  - The bus is driven for the first MODE_WIN cycles of the read.
  - From then until completion, db_oe is 0.
  - At completion the bus is driven with the new result, and rdy_low is released.
- R6 (both modes):
  - rdy_low is 1 from the first edge that sees chip-select low.
  - During the first cycles of a read the bus shows the previous conversion's result.
  - In mode 1, rdy_low returns to 0 at the edge that sees chip-select high.
- R7: int_n returns to 1 at the edge that sees a read end (chip-select or read rising). It also returns to 1 at the start edge of a new conversion. Otherwise it stays low after completion.
- R8: A start that arrives while a conversion is running is ignored. The running conversion keeps its channel and completion time, and the next read shows its result.
- R9: After reset:
  - db_oe is 0, int_n is 1 and rdy_low is 0.
  - The stored result is 0x00.
- R10: For every sample word, the 8-bit result equals the sample word itself, including 0x00, 0xFF, 0x0F and 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip-select |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | CHAN_BITS | Channel address |
| samples | input | 8·2^CHAN_BITS | One 8-bit sample word per channel |
| db_q | output | 8 | Result bus data |
| db_oe | output | 1 | Result bus drive enable (0 = high impedance) |
| int_n | output | 1 | Active-low completion flag |
| rdy_low | output | 1 | Open-drain pull-low request for the host wait line |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value |
|---|---|
| CHAN_BITS | 3 |
| TRACK_CYC | 8 |
| FINE_CYC | 5 |
| MODE_WIN | 3 |
| ENC_COUNT | 1 (counting encoder) |

The short intervals put every phase boundary within a few clock cycles. This means the bench can:

- change an input exactly one edge before or after the sample point;
- raise a second start in the middle of tracking;
- see where the mode-0 bus window closes well before completion.

The eight channels let every address and the extreme code values appear in one run.

// File: rtl/hfa_pkg.sv
package hfa_pkg;
   localparam int NIB_W  = 4;
   localparam int WORD_W = 2 * NIB_W;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_TRACK = 2'd1,
      PH_FINE  = 2'd2
   } phase_t;
endpackage

// File: rtl/hfa_therm_enc.sv
// Thermometer to binary encoder; the variant is picked by COUNT_STYLE.
module hfa_therm_enc #(
   parameter int TAPS        = 15,
   parameter int OUT_W       = 4,
   parameter int COUNT_STYLE = 1
) (
   input  logic [TAPS-1:0]  therm,
   output logic [OUT_W-1:0] bin
);
   initial begin
      assert ((1 << OUT_W) > TAPS) else $error("OUT_W too small for TAPS");
   end

   generate
      if (COUNT_STYLE != 0) begin : g_count
         // Ones count: tolerant of isolated bubbles.
         always_comb begin
            bin = '0;
            for (int i = 0; i < TAPS; i++) bin = bin + OUT_W'(therm[i]);
         end
      end else begin : g_top
         // Highest set tap: shallower adder-free path.
         always_comb begin
            bin = '0;
            for (int i = 0; i < TAPS; i++) if (therm[i]) bin = OUT_W'(i + 1);
         end
      end
   endgenerate
endmodule

// File: rtl/hfa_ladder.sv
// One comparator bank against the ladder plus its encoder.
module hfa_ladder #(
   parameter int NIB_W       = 4,
   parameter int COUNT_STYLE = 1
) (
   input  logic [NIB_W-1:0] level,
   output logic [NIB_W-1:0] code
);
   localparam int TAPS = (1 << NIB_W) - 1;

   logic [TAPS-1:0] therm;

   genvar k;
   generate
      for (k = 0; k < TAPS; k++) begin : g_cmp
         assign therm[k] = (level >= NIB_W'(k + 1));
      end
   endgenerate

   hfa_therm_enc #(
      .TAPS       (TAPS),
      .OUT_W      (NIB_W),
      .COUNT_STYLE(COUNT_STYLE)
   ) u_enc (
      .therm(therm),
      .bin  (code)
   );
endmodule

// File: rtl/hfa_seq.sv
module hfa_seq
   import hfa_pkg::*;
#(
   parameter int CHAN_BITS = 3,
   parameter int TRACK_CYC = 100,
   parameter int FINE_CYC  = 60,
   parameter int MODE_WIN  = 9,
   parameter int ENC_COUNT = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cs_n,
   input  logic                              rd_n,
   input  logic [CHAN_BITS-1:0]              addr,
   input  logic [WORD_W*(1<<CHAN_BITS)-1:0]  samples,
   output logic [WORD_W-1:0]                 db_q,
   output logic                              db_oe,
   output logic                              int_n,
   output logic                              rdy_low
);
   localparam int NCH   = 1 << CHAN_BITS;
   localparam int LONG  = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC;
   localparam int CNT_W = $clog2(LONG + 1);
   localparam int AGE_W = $clog2(MODE_WIN + 1);

   initial begin
      assert (CHAN_BITS >= 1 && CHAN_BITS <= 4) else $error("CHAN_BITS out of range");
      assert (TRACK_CYC >= 1 && FINE_CYC >= 1) else $error("phase lengths must be positive");
      assert (MODE_WIN >= 1 && MODE_WIN < TRACK_CYC + FINE_CYC)
         else $error("MODE_WIN must end before completion");
      assert (NCH * WORD_W == $bits(samples)) else $error("sample bus width mismatch");
   end

   phase_t               phase;
   logic [CNT_W-1:0]     cnt_q;
   logic [CHAN_BITS-1:0] chan_q;
   logic [WORD_W-1:0]    held_q, res_q, prev_q, live, resid;
   logic [NIB_W-1:0]     coarse_q, coarse_bin, fine_bin;
   logic [AGE_W-1:0]     age_q;
   logic                 sel_now, sel_d, cs_d, start_p, accept, done;
   logic                 own_done_q, rdy_rel_q, int_q;

   assign sel_now = ~cs_n & ~rd_n;
   assign start_p = sel_now & ~sel_d;
   assign accept  = start_p & (phase == PH_IDLE);
   assign done    = (phase == PH_FINE) && (cnt_q == '0);
   assign live    = samples[int'(chan_q) * WORD_W +: WORD_W];
   assign resid   = held_q - {coarse_q, {NIB_W{1'b0}}};

   hfa_ladder #(.NIB_W(NIB_W), .COUNT_STYLE(ENC_COUNT)) u_coarse (
      .level(live[WORD_W-1:NIB_W]),
      .code (coarse_bin)
   );

   hfa_ladder #(.NIB_W(NIB_W), .COUNT_STYLE(ENC_COUNT)) u_fine (
      .level(resid[NIB_W-1:0]),
      .code (fine_bin)
   );

   // Conversion phase sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt_q    <= '0;
         chan_q   <= '0;
         held_q   <= '0;
         coarse_q <= '0;
         res_q    <= '0;
         prev_q   <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (accept) begin
               chan_q <= addr;
               prev_q <= res_q;
               cnt_q  <= CNT_W'(TRACK_CYC - 1);
               phase  <= PH_TRACK;
            end
            PH_TRACK: if (cnt_q == '0) begin
               held_q               <= live;
               coarse_q             <= coarse_bin;
               res_q[WORD_W-1:NIB_W] <= coarse_bin;
               cnt_q                <= CNT_W'(FINE_CYC - 1);
               phase                <= PH_FINE;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            PH_FINE: if (cnt_q == '0) begin
               res_q[NIB_W-1:0] <= fine_bin;
               phase            <= PH_IDLE;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // Host strobe tracking and status outputs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_d      <= 1'b0;
         cs_d       <= 1'b0;
         age_q      <= '0;
         own_done_q <= 1'b0;
         rdy_rel_q  <= 1'b0;
         int_q      <= 1'b1;
      end else begin
         sel_d <= sel_now;
         cs_d  <= ~cs_n;

         if (start_p || !sel_now) age_q <= '0;
         else if (age_q < AGE_W'(MODE_WIN)) age_q <= age_q + 1'b1;

         if (!sel_now || accept) own_done_q <= 1'b0;
         else if (done)          own_done_q <= 1'b1;

         if (cs_n || accept)         rdy_rel_q <= 1'b0;
         else if (done && sel_now)   rdy_rel_q <= 1'b1;

         if (done)                               int_q <= 1'b0;
         else if (accept || (sel_d && !sel_now)) int_q <= 1'b1;
      end
   end

   assign db_oe   = sel_d & (own_done_q | (age_q < AGE_W'(MODE_WIN)));
   assign db_q    = own_done_q ? res_q : prev_q;
   assign int_n   = int_q;
   assign rdy_low = cs_d & ~rdy_rel_q;
endmodule

// File: rtl/hfa_seq_chk.sv
module hfa_seq_chk
   import hfa_pkg::*;
#(
   parameter int CHAN_BITS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic                 rd_n,
   input logic                 db_oe,
   input logic                 int_n,
   input logic                 rdy_low,
   input logic                 sel_d,
   input phase_t               phase,
   input logic [CHAN_BITS-1:0] chan_q
);
   // R5
   bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_oe |-> $past(!cs_n && !rd_n));

   // R4
   done_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> ($past(phase) == PH_FINE));

   // R7
   int_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_n) |-> ($past(!cs_n && !rd_n) != $past(sel_d)));

   // R8
   busy_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(chan_q));

   // R6
   rdy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_low |-> $past(!cs_n));
endmodule

bind hfa_seq hfa_seq_chk #(.CHAN_BITS(CHAN_BITS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_n   (cs_n),
   .rd_n   (rd_n),
   .db_oe  (db_oe),
   .int_n  (int_n),
   .rdy_low(rdy_low),
   .sel_d  (sel_d),
   .phase  (phase),
   .chan_q (chan_q)
);

// File: tb/tb_hfa_seq.sv
`timescale 1ns/1ps
module tb_hfa_seq;
   localparam int CB = 3;
   localparam int T  = 8;
   localparam int F  = 5;
   localparam int W  = 3;
   localparam int NC = 1 << CB;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cs_n = 1'b1, rd_n = 1'b1;
   logic [CB-1:0]     addr = '0;
   logic [8*NC-1:0]   samp_v = '0;
   logic [7:0]        db_q;
   logic              db_oe, int_n, rdy_low;

   int nchk = 0, nfail = 0;
   logic [7:0] sb_q[$];
   logic [7:0] last_res = 8'h00;
   bit finished = 0;

   always #5 clk = ~clk;

   hfa_seq #(
      .CHAN_BITS(CB), .TRACK_CYC(T), .FINE_CYC(F), .MODE_WIN(W), .ENC_COUNT(1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
      .samples(samp_v), .db_q(db_q), .db_oe(db_oe), .int_n(int_n), .rdy_low(rdy_low)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_ch(input int ch, input logic [7:0] v);
      samp_v[ch*8 +: 8] = v;
   endtask

   // Monitor side of the scoreboard: pop the oldest pending result and compare.
   task automatic sb_compare(input string req, input logic [7:0] act);
      if (sb_q.size() == 0) begin
         chk({req, " (scoreboard empty)"}, act, last_res);
      end else begin
         last_res = sb_q.pop_front();
         chk(req, act, last_res);
      end
   endtask

   // Driver: one read transaction, mode 0 or mode 1.
   task automatic do_read(input bit mode1, input int a, input logic [7:0] exp,
                          input int alt_a, input int late_ch, input logic [7:0] late_v,
                          input int late_k, input bit intrude);
      @(negedge clk);
      addr = CB'(a); cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk); // after start edge
      chk("R6 ready pulled low on select", {7'b0, rdy_low}, 8'h01);
      chk("R6 bus driven at read start", {7'b0, db_oe}, 8'h01);
      chk("R7 int_n high at start", {7'b0, int_n}, 8'h01);
      sb_compare("R6 previous result on bus", db_q);
      sb_q.push_back(exp);
      if (mode1) begin cs_n = 1'b1; rd_n = 1'b1; end
      for (int k = 1; k <= T + F - 1; k++) begin
         @(negedge clk);
         if (k == 1) begin
            addr = CB'(alt_a); // R1: change after capture
            if (mode1) begin
               chk("R6 ready released at cs high", {7'b0, rdy_low}, 8'h00);
               chk("R6 bus off after short read", {7'b0, db_oe}, 8'h00);
               chk("R7 int_n high after read end", {7'b0, int_n}, 8'h01);
            end
         end
         if (!mode1 && k == W) chk("R5 bus floats during wait", {7'b0, db_oe}, 8'h00);
         if (intrude && k == 2) begin addr = CB'(5); cs_n = 1'b0; rd_n = 1'b0; end
         if (intrude && k == 3) begin cs_n = 1'b1; rd_n = 1'b1; end
         if (late_ch >= 0 && k == late_k) set_ch(late_ch, late_v); // R3
         if (k == T + F - 1) begin
            chk("R4 int_n still high one cycle before done", {7'b0, int_n}, 8'h01);
            if (!mode1) chk("R5 ready held during conversion", {7'b0, rdy_low}, 8'h01);
         end
      end
      @(negedge clk);
      chk("R4 int_n low at completion", {7'b0, int_n}, 8'h00);
      if (!mode1) begin
         chk("R5 bus driven at completion", {7'b0, db_oe}, 8'h01);
         sb_compare("R10 R2 R1 mode 0 result", db_q);
         chk("R5 ready released at completion", {7'b0, rdy_low}, 8'h00);
         cs_n = 1'b1; rd_n = 1'b1;
         @(negedge clk);
         chk("R7 int_n high after read rises", {7'b0, int_n}, 8'h01);
         chk("R5 bus off after read", {7'b0, db_oe}, 8'h00);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9
      chk("R9 bus off after reset", {7'b0, db_oe}, 8'h00);
      chk("R9 int_n high after reset", {7'b0, int_n}, 8'h01);
      chk("R9 ready idle after reset", {7'b0, rdy_low}, 8'h00);
      set_ch(0, 8'h00); set_ch(1, 8'hFF); set_ch(2, 8'h5A); set_ch(3, 8'hA5);
      set_ch(4, 8'h0F); set_ch(5, 8'hF0); set_ch(6, 8'h81); set_ch(7, 8'h3C);
      // R1, R2, R9: mode 0 read of ch2 with address moved mid-conversion
      do_read(0, 2, 8'h5A, 7, -1, 8'h00, 0, 0);
      // R3, R10: late change on ch1 after the sample edge is ignored
      do_read(0, 1, 8'hFF, 1, 1, 8'h00, T, 0);
      set_ch(1, 8'hFF);
      // R6: pipelined reads
      do_read(1, 0, 8'h00, 0, -1, 8'h00, 0, 0);
      // R3, R8: change before sample edge is taken; intruding start ignored
      do_read(1, 3, 8'h77, 3, 3, 8'h77, T - 1, 1);
      do_read(1, 4, 8'h0F, 4, -1, 8'h00, 0, 0);
      // R10: extreme codes, back in mode 0
      do_read(0, 5, 8'hF0, 5, -1, 8'h00, 0, 0);
      do_read(0, 6, 8'h81, 6, -1, 8'h00, 0, 0);
      do_read(0, 7, 8'h3C, 7, -1, 8'h00, 0, 0);
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++; nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule